// File: doc/BRIEF.md
# Parallel Bus Port with Device Select

This block couples an 8-bit device-enable register with a bidirectional 8-bit parallel bus. The enable register holds two independent 4-bit codes. Each code is decoded into a one-hot group of 16 active-high select lines for external devices. Code 0 in either group is the idle "no device" choice and has no internal effect. Code 1 in the low group switches the block's own output data register onto the bus. Code 1 in the high group makes the block's input latch sample the bus.

The CPU writes the enable register and the output data register through write strobes, and reads the input latch through a read port. The bus side has a gated output byte with its output enable, the resolved input byte, and the two select vectors.

Resolving the bus lives outside the block. Undriven lines are held low by weak pull-downs. As a result, an input sample taken while nobody drives the bus yields zero. While the low code stays at 1, a second device chosen through the high code can read the byte the block puts out. That device may be the block's own input latch.

Top module: `pbus_port`

## Requirements
- R1: After reset the enable register, the output data register and the input latch are all zero, so `sel_lo_o` = 0x0001, `sel_hi_o` = 0x0001, `bus_oe_o` = 0, `bus_o` = 0 and `pin_rdata_o` = 0.
- R2: `sel_lo_o` is one-hot and equals 1 shifted left by enable bits [3:0]; bit 0 marks the null device.
- R3: `sel_hi_o` is one-hot and equals 1 shifted left by enable bits [7:4], independent of the low code.
- R4: `bus_oe_o` is 1 exactly when enable bits [3:0] equal 1.
- R5: A write to the output data register only stores the byte. `bus_o` shows the stored byte while `bus_oe_o` is 1 and shows 0x00 otherwise.
- R6: The input latch samples `bus_i` on the first clock edge at which enable bits [7:4] equal 1 after holding another value. This is the edge following the enable write. The sampled byte is visible on `pin_rdata_o` after that edge.
- R7: The input latch keeps its value at every other edge. This covers edges while the high code stays 1, an edge where the same code 1 is written again, and edges under any other high code. It holds even when `bus_i` or the output data register changes.
- R8: With no driver active, the pulled-down bus reads 0x00 and a sample yields 0x00.
- R9: With enable = 0x11, the latch samples the block's own output byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_we_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | 8 | Enable register write data: [7:4] high code, [3:0] low code |
| pout_we_i | input | 1 | Output data register write strobe |
| pout_wdata_i | input | 8 | Output data register write data |
| pin_rdata_o | output | 8 | Input latch contents |
| bus_o | output | 8 | Byte driven onto the bus, 0 while tri-stated |
| bus_oe_o | output | 1 | Bus output enable |
| bus_i | input | 8 | Resolved bus value |
| sel_lo_o | output | 16 | One-hot selects from the low code |
| sel_hi_o | output | 16 | One-hot selects from the high code |

## Verification
The bench uses the default widths: an 8-bit data path and 4-bit select codes. With these widths, all 256 enable values can be written one after another. Every decoded pair, the output enable and the gated output byte are compared against shifts computed in the bench. A directed sequence then covers the capture edge. It exercises the latch while the bus is driven by the block, by a modelled external device, and by no one. It also covers holding across repeated, changed and cleared high codes.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  parameter int unsigned NULL_CODE  = 0;
  parameter int unsigned DRIVE_CODE = 1;  // low group: own output onto bus
  parameter int unsigned LATCH_CODE = 1;  // high group: sample bus
endpackage

// File: rtl/pbus_sel_dec.sv
module pbus_sel_dec #(
  parameter int SEL_W = 4,
  localparam int NSEL = 1 << SEL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] code_i,
  output logic [NSEL-1:0]  sel_o
);
  for (genvar i = 0; i < NSEL; i++) begin : g_line
    assign sel_o[i] = (code_i == SEL_W'(i));
  end

  p_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(sel_o) == 1);
endmodule

// File: rtl/pbus_out_reg.sv
module pbus_out_reg #(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [SEL_W-1:0]  code_i,
  output logic [DATA_W-1:0] bus_o,
  output logic              oe_o
);
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   data_q <= '0;
    else if (we_i) data_q <= wdata_i;
  end

  assign oe_o  = (code_i == SEL_W'(pbus_pkg::DRIVE_CODE));
  assign bus_o = oe_o ? data_q : '0;

  p_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> bus_o == '0);
  p_store_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && oe_o |=> (oe_o -> bus_o == $past(wdata_i)));
endmodule

// File: rtl/pbus_in_latch.sv
module pbus_in_latch #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= 1'b0;
      rdata_o <= '0;
    end else begin
      sel_q <= sel_i;
      if (sel_i && !sel_q) rdata_o <= bus_i;  // first cycle of selection
    end
  end

  p_capture_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sel_i) |=> rdata_o == $past(bus_i));
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(sel_i) |=> $stable(rdata_o));
endmodule

// File: rtl/pbus_port.sv
module pbus_port #(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 4,
  localparam int NSEL  = 1 << SEL_W,
  localparam int EN_W  = 2 * SEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_we_i,
  input  logic [EN_W-1:0]   en_wdata_i,
  input  logic              pout_we_i,
  input  logic [DATA_W-1:0] pout_wdata_i,
  output logic [DATA_W-1:0] pin_rdata_o,
  output logic [DATA_W-1:0] bus_o,
  output logic              bus_oe_o,
  input  logic [DATA_W-1:0] bus_i,
  output logic [NSEL-1:0]   sel_lo_o,
  output logic [NSEL-1:0]   sel_hi_o
);
  logic [EN_W-1:0]  en_q;
  logic [SEL_W-1:0] code_lo, code_hi;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_q <= '0;
    else if (en_we_i) en_q <= en_wdata_i;
  end

  assign code_lo = en_q[SEL_W-1:0];
  assign code_hi = en_q[EN_W-1:SEL_W];

  pbus_sel_dec #(.SEL_W(SEL_W)) u_dec_lo (
    .clk_i(clk_i), .rst_ni(rst_ni), .code_i(code_lo), .sel_o(sel_lo_o));
  pbus_sel_dec #(.SEL_W(SEL_W)) u_dec_hi (
    .clk_i(clk_i), .rst_ni(rst_ni), .code_i(code_hi), .sel_o(sel_hi_o));

  pbus_out_reg #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(pout_we_i), .wdata_i(pout_wdata_i),
    .code_i(code_lo), .bus_o(bus_o), .oe_o(bus_oe_o));

  pbus_in_latch #(.DATA_W(DATA_W)) u_in (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_hi_o[pbus_pkg::LATCH_CODE]),
    .bus_i(bus_i), .rdata_o(pin_rdata_o));

  p_oe_sel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o == sel_lo_o[pbus_pkg::DRIVE_CODE]);
  p_en_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_we_i |=> sel_lo_o[$past(en_wdata_i[SEL_W-1:0])]
             && sel_hi_o[$past(en_wdata_i[EN_W-1:SEL_W])]);
endmodule

// File: tb/tb_pbus_port.sv
`timescale 1ns/100ps
module tb_pbus_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_we = 1'b0, pout_we = 1'b0;
  logic [7:0]  en_wdata = '0, pout_wdata = '0;
  logic [7:0]  pin_rdata, bus_o, bus_i;
  logic        bus_oe;
  logic [15:0] sel_lo, sel_hi;
  logic        ext_en = 1'b0;
  logic [7:0]  ext_val = '0;
  int          n_run = 0, n_fail = 0;
  logic        done = 1'b0;

  always #2.5 clk = ~clk;

  // pull-down bus: undriven lines read 0
  assign bus_i = (bus_oe ? bus_o : 8'h00) | (ext_en ? ext_val : 8'h00);

  pbus_port dut (
    .clk_i(clk), .rst_ni(rst_n), .en_we_i(en_we), .en_wdata_i(en_wdata),
    .pout_we_i(pout_we), .pout_wdata_i(pout_wdata), .pin_rdata_o(pin_rdata),
    .bus_o(bus_o), .bus_oe_o(bus_oe), .bus_i(bus_i),
    .sel_lo_o(sel_lo), .sel_hi_o(sel_hi));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr_en(input logic [7:0] v);
    en_we = 1'b1; en_wdata = v; tick(); en_we = 1'b0;
  endtask

  task automatic wr_out(input logic [7:0] v);
    pout_we = 1'b1; pout_wdata = v; tick(); pout_we = 1'b0;
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 sel_lo", 32'(sel_lo), 32'h1);
    chk("R1 sel_hi", 32'(sel_hi), 32'h1);
    chk("R1 oe", 32'(bus_oe), 0);
    chk("R1 bus_o", 32'(bus_o), 0);
    chk("R1 rdata", 32'(pin_rdata), 0);

    wr_out(8'h96);
    for (int e = 0; e < 256; e++) begin
      wr_en(8'(e));
      chk("R2 sel_lo", 32'(sel_lo), 32'(1 << (e % 16)));
      chk("R3 sel_hi", 32'(sel_hi), 32'(1 << (e / 16)));
      chk("R4 oe", 32'(bus_oe), 32'((e % 16) == 1));
      chk("R5 bus_o", 32'(bus_o), ((e % 16) == 1) ? 32'h96 : 32'h0);
    end

    wr_en(8'h00); tick();
    wr_out(8'hA5);
    chk("R5 stored while tristated oe", 32'(bus_oe), 0);
    chk("R5 stored while tristated bus", 32'(bus_o), 0);
    wr_en(8'h01);
    chk("R5 shown when selected", 32'(bus_o), 32'hA5);
    wr_en(8'h11); tick();
    chk("R9 loopback sample", 32'(pin_rdata), 32'hA5);
    wr_out(8'h3C);
    chk("R5 new byte on bus", 32'(bus_o), 32'h3C);
    tick();
    chk("R7 hold while selected", 32'(pin_rdata), 32'hA5);
    wr_en(8'h11); tick();
    chk("R7 rewrite same code", 32'(pin_rdata), 32'hA5);
    wr_en(8'h00); tick();
    chk("R7 hold after deselect", 32'(pin_rdata), 32'hA5);
    wr_en(8'h10); tick();
    chk("R8 undriven sample", 32'(pin_rdata), 0);
    ext_en = 1'b1; ext_val = 8'h5A;
    wr_en(8'h20); tick();
    chk("R7 other code no sample", 32'(pin_rdata), 0);
    wr_en(8'h10); tick();
    chk("R6 external sample", 32'(pin_rdata), 32'h5A);
    ext_val = 8'hC3; tick(); tick();
    chk("R7 bus change ignored", 32'(pin_rdata), 32'h5A);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule